// File: doc/BRIEF.md
# Serial Clock-Generator Configuration Writer

This block is the host-side engine that loads a new setting into a serially programmed clock synthesizer. It is given the divider and option fields and a one-cycle `start` pulse. It first checks the divider words. A request with a forbidden reference or feedback divider is refused: `err` pulses and the serial lines never move. A legal request is packed into a 24-bit frame and sent most significant bit first on `ser_clk` / `ser_data`, while `ser_strobe` stays low. After the last bit it waits a minimum gap, then raises `ser_strobe` for a minimum width to latch the frame.

All interface timing is derived from parameters given in picoseconds together with the system clock period. Each phase (data setup before a rising serial edge, hold after it, the gap before the strobe, and the strobe width) lasts the ceiling of its time over the period, and at least one cycle. `busy` covers the whole transfer. `done` marks its end.

Top module: `cfg_serial_writer`

## Requirements
- R1: The frame is sent MSB first, one bit per `ser_clk` rising edge, 24 bits in this order: `cap_code[1]`, `cap_code[0]`, `duty_bit`, `aux_sel[1]`, `aux_sel[0]`, `odiv_sel[2:0]`, `vco_word[8:0]`, `rdiv_word[6:0]`. With rdiv 59, vco 276, odiv 001, aux 10, duty 1 and cap 00, the stream is 00110001 10001010 00111011.
- R2: `ser_strobe` is low whenever `ser_clk` rises and during every bit of a frame.
- R3: Before each `ser_clk` rising edge, `ser_data` has held its value with `ser_clk` low for at least ceil(T_SETUP/period) cycles (1 cycle at defaults).
- R4: `ser_clk` stays high for at least ceil(T_HOLD/period) cycles (1 at defaults), and `ser_data` does not change while it is high.
- R5: At least ceil(T_WAIT/period) cycles (1 at defaults) pass with `ser_clk` low between the last falling edge and the rise of `ser_strobe`.
- R6: `ser_strobe` stays high for exactly max(1, ceil(T_PULSE/period)) cycles (2 at defaults).
- R7: A start with `vco_word` < 4 or `rdiv_word` == 0 raises `err` for exactly one cycle, starting the cycle after `start`. `busy` stays low, and `ser_clk`, `ser_data` and `ser_strobe` stay low.
- R8: A `start` while `busy` is high is ignored: no extra frame is sent, and the frame in progress keeps its contents.
- R9: `busy` is high from the cycle after an accepted start until `ser_strobe` falls. `done` is high for exactly one cycle, the first cycle in which `ser_strobe` is low again, and at no other time.
- R10: During and after reset, with no start, all outputs are low.
- R11: The boundary words vco 4 / rdiv 1 and vco 511 / rdiv 127 are accepted and sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to send the current fields |
| rdiv_word | input | 7 | Reference divider word |
| vco_word | input | 9 | Feedback (VCO) divider word |
| odiv_sel | input | 3 | Output divider select code |
| aux_sel | input | 2 | Second-output function select |
| duty_bit | input | 1 | Duty-cycle trim bit |
| cap_code | input | 2 | Crystal load-capacitance code |
| ser_clk | output | 1 | Serial clock to the synthesizer |
| ser_data | output | 1 | Serial data, changed only while ser_clk is low |
| ser_strobe | output | 1 | Latch pulse after the frame |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse for illegal words |

## Verification
The assertions assume that the field inputs are stable in the cycle where `start` is high. They also assume that `start` is a single-cycle pulse, sampled synchronously to `clk`. The driver changes fields and `start` only on the falling clock edge and holds `start` high for one cycle. It issues a second start only in the ignored-start case, while a frame is in progress. Field values are taken from the reference example, the two legal boundary pairs, three illegal pairs and alternating bit patterns.

// File: rtl/cfg_writer_pkg.sv
package cfg_writer_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_SETUP = 3'd1,
      ST_HIGH  = 3'd2,
      ST_WAIT  = 3'd3,
      ST_PULSE = 3'd4
   } wr_state_e;

   // cycles covering a time span, never below one
   function automatic int span_cycles(input int span_ps, input int period_ps);
      int c;
      c = (span_ps + period_ps - 1) / period_ps;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/cfg_frame_pack.sv
module cfg_frame_pack #(
   parameter int RDIV_W   = 7,
   parameter int VCO_W    = 9,
   parameter int ODIV_W   = 3,
   parameter int AUX_W    = 2,
   parameter int CAP_W    = 2,
   parameter int VCO_MIN  = 4,
   parameter int RDIV_MIN = 1,
   parameter int CHECK_EN = 1,
   localparam int FRAME_W = CAP_W + 1 + AUX_W + ODIV_W + VCO_W + RDIV_W
) (
   input  logic [RDIV_W-1:0]  rdiv_word,
   input  logic [VCO_W-1:0]   vco_word,
   input  logic [ODIV_W-1:0]  odiv_sel,
   input  logic [AUX_W-1:0]   aux_sel,
   input  logic               duty_bit,
   input  logic [CAP_W-1:0]   cap_code,
   output logic [FRAME_W-1:0] frame,
   output logic               legal
);

   assign frame = {cap_code, duty_bit, aux_sel, odiv_sel, vco_word, rdiv_word};

   generate
      if (CHECK_EN != 0) begin : g_check
         assign legal = (vco_word >= VCO_W'(VCO_MIN)) && (rdiv_word >= RDIV_W'(RDIV_MIN));
      end else begin : g_nocheck
         assign legal = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/cfg_phase_timer.sv
module cfg_phase_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (load)          cnt_q <= load_val;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/cfg_serial_writer.sv
module cfg_serial_writer
   import cfg_writer_pkg::*;
#(
   parameter int RDIV_W        = 7,
   parameter int VCO_W         = 9,
   parameter int ODIV_W        = 3,
   parameter int AUX_W         = 2,
   parameter int CAP_W         = 2,
   parameter int VCO_MIN       = 4,
   parameter int RDIV_MIN      = 1,
   parameter int CHECK_EN      = 1,
   parameter int CLK_PERIOD_PS = 20000,
   parameter int T_SETUP_PS    = 10000,
   parameter int T_HOLD_PS     = 10000,
   parameter int T_WAIT_PS     = 10000,
   parameter int T_PULSE_PS    = 40000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [RDIV_W-1:0] rdiv_word,
   input  logic [VCO_W-1:0]  vco_word,
   input  logic [ODIV_W-1:0] odiv_sel,
   input  logic [AUX_W-1:0]  aux_sel,
   input  logic              duty_bit,
   input  logic [CAP_W-1:0]  cap_code,
   output logic              ser_clk,
   output logic              ser_data,
   output logic              ser_strobe,
   output logic              busy,
   output logic              done,
   output logic              err
);

   localparam int FRAME_W   = CAP_W + 1 + AUX_W + ODIV_W + VCO_W + RDIV_W;
   localparam int SETUP_CYC = span_cycles(T_SETUP_PS, CLK_PERIOD_PS);
   localparam int HOLD_CYC  = span_cycles(T_HOLD_PS,  CLK_PERIOD_PS);
   localparam int WAIT_CYC  = span_cycles(T_WAIT_PS,  CLK_PERIOD_PS);
   localparam int PULSE_CYC = span_cycles(T_PULSE_PS, CLK_PERIOD_PS);
   localparam int MAX_CYC   = max4(SETUP_CYC, HOLD_CYC, WAIT_CYC, PULSE_CYC);
   localparam int CNT_W     = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
   localparam int BIT_W     = $clog2(FRAME_W);

   generate
      if (CLK_PERIOD_PS < 1) begin : g_bad_period
         $error("cfg_serial_writer: CLK_PERIOD_PS must be positive");
      end
      if (FRAME_W < 2) begin : g_bad_frame
         $error("cfg_serial_writer: frame must hold at least two bits");
      end
      if (VCO_MIN >= (1 << VCO_W) || RDIV_MIN >= (1 << RDIV_W)) begin : g_bad_min
         $error("cfg_serial_writer: divider minimum does not fit its field");
      end
   endgenerate

   wr_state_e           state_q;
   logic [FRAME_W-1:0]  frame, shreg_q;
   logic                legal;
   logic [BIT_W-1:0]    bit_idx_q;
   logic                sclk_q, strobe_q, done_q, err_q;
   logic                tmr_load, tmr_expired;
   logic [CNT_W-1:0]    tmr_val;
   logic                last_bit;

   cfg_frame_pack #(
      .RDIV_W(RDIV_W), .VCO_W(VCO_W), .ODIV_W(ODIV_W), .AUX_W(AUX_W), .CAP_W(CAP_W),
      .VCO_MIN(VCO_MIN), .RDIV_MIN(RDIV_MIN), .CHECK_EN(CHECK_EN)
   ) u_pack (
      .rdiv_word(rdiv_word), .vco_word(vco_word), .odiv_sel(odiv_sel),
      .aux_sel(aux_sel), .duty_bit(duty_bit), .cap_code(cap_code),
      .frame(frame), .legal(legal)
   );

   cfg_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_expired)
   );

   assign last_bit = (bit_idx_q == BIT_W'(FRAME_W - 1));

   // length of the phase about to begin, loaded as cycles minus one
   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (state_q)
         ST_IDLE: if (start && legal) begin
            tmr_load = 1'b1; tmr_val = CNT_W'(SETUP_CYC - 1);
         end
         ST_SETUP: if (tmr_expired) begin
            tmr_load = 1'b1; tmr_val = CNT_W'(HOLD_CYC - 1);
         end
         ST_HIGH: if (tmr_expired) begin
            tmr_load = 1'b1;
            tmr_val  = last_bit ? CNT_W'(WAIT_CYC - 1) : CNT_W'(SETUP_CYC - 1);
         end
         ST_WAIT: if (tmr_expired) begin
            tmr_load = 1'b1; tmr_val = CNT_W'(PULSE_CYC - 1);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         shreg_q   <= '0;
         bit_idx_q <= '0;
         sclk_q    <= 1'b0;
         strobe_q  <= 1'b0;
         done_q    <= 1'b0;
         err_q     <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (start) begin
               if (legal) begin
                  shreg_q   <= frame;
                  bit_idx_q <= '0;
                  state_q   <= ST_SETUP;
               end else begin
                  err_q <= 1'b1;
               end
            end
            ST_SETUP: if (tmr_expired) begin
               sclk_q  <= 1'b1;
               state_q <= ST_HIGH;
            end
            ST_HIGH: if (tmr_expired) begin
               sclk_q <= 1'b0;
               if (last_bit) begin
                  state_q <= ST_WAIT;
               end else begin
                  shreg_q   <= {shreg_q[FRAME_W-2:0], 1'b0};
                  bit_idx_q <= bit_idx_q + 1'b1;
                  state_q   <= ST_SETUP;
               end
            end
            ST_WAIT: if (tmr_expired) begin
               strobe_q <= 1'b1;
               state_q  <= ST_PULSE;
            end
            ST_PULSE: if (tmr_expired) begin
               strobe_q <= 1'b0;
               done_q   <= 1'b1;
               shreg_q  <= '0;
               state_q  <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign ser_clk    = sclk_q;
   assign ser_data   = shreg_q[FRAME_W-1];
   assign ser_strobe = strobe_q;
   assign busy       = (state_q != ST_IDLE);
   assign done       = done_q;
   assign err        = err_q;

endmodule

// File: rtl/cfg_serial_writer_chk.sv
module cfg_serial_writer_chk #(
   parameter int PULSE_CYC = 2
) (
   input logic clk,
   input logic rst_n,
   input logic ser_clk,
   input logic ser_data,
   input logic ser_strobe,
   input logic busy,
   input logic done,
   input logic err
);

   logic [15:0] strobe_len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          strobe_len_q <= '0;
      else if (ser_strobe) strobe_len_q <= strobe_len_q + 1'b1;
      else                 strobe_len_q <= '0;
   end

   p_strobe_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ser_clk) |-> !ser_strobe);

   p_setup_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ser_clk) |-> $stable(ser_data));

   p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

   p_pulse_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ser_strobe) |-> (strobe_len_q == 16'(PULSE_CYC)));

   p_err_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!busy && !ser_clk && !ser_strobe && !ser_data));

   p_err_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> !err);

   p_done_after_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!ser_strobe && $past(ser_strobe)));

   p_idle_lines_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!ser_clk && !ser_strobe));

endmodule

bind cfg_serial_writer cfg_serial_writer_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
   .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
   .ser_strobe(ser_strobe), .busy(busy), .done(done), .err(err)
);

// File: tb/cfg_serial_writer_bench.sv
module cfg_serial_writer_bench;

   localparam int PER_NS  = 20;
   localparam int SETUP_E = (10 + PER_NS - 1) / PER_NS;
   localparam int HOLD_E  = (10 + PER_NS - 1) / PER_NS;
   localparam int WAIT_E  = (10 + PER_NS - 1) / PER_NS;
   localparam int PULSE_E = (40 + PER_NS - 1) / PER_NS;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [6:0] rdiv_word = '0;
   logic [8:0] vco_word = '0;
   logic [2:0] odiv_sel = '0;
   logic [1:0] aux_sel = '0;
   logic       duty_bit = 1'b0;
   logic [1:0] cap_code = '0;
   logic       ser_clk, ser_data, ser_strobe, busy, done, err;

   int checks = 0;
   int fails  = 0;
   int frames_sent = 0;
   int dones_seen  = 0;
   logic [23:0] exp_q[$];

   always #(PER_NS / 2) clk = ~clk;

   cfg_serial_writer u_cfg_serial_writer (
      .clk(clk), .rst_n(rst_n), .start(start), .rdiv_word(rdiv_word),
      .vco_word(vco_word), .odiv_sel(odiv_sel), .aux_sel(aux_sel),
      .duty_bit(duty_bit), .cap_code(cap_code), .ser_clk(ser_clk),
      .ser_data(ser_data), .ser_strobe(ser_strobe), .busy(busy),
      .done(done), .err(err)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [23:0] build(input logic [1:0] cap, input logic duty,
                                         input logic [1:0] aux, input logic [2:0] od,
                                         input logic [8:0] vco, input logic [6:0] rd);
      return {cap, duty, aux, od, vco, rd};
   endfunction

   task automatic apply(input logic [1:0] cap, input logic duty, input logic [1:0] aux,
                        input logic [2:0] od, input logic [8:0] vco, input logic [6:0] rd);
      cap_code = cap; duty_bit = duty; aux_sel = aux; odiv_sel = od;
      vco_word = vco; rdiv_word = rd;
   endtask

   task automatic send(input logic [1:0] cap, input logic duty, input logic [1:0] aux,
                       input logic [2:0] od, input logic [8:0] vco, input logic [6:0] rd,
                       input bit ok, input string req);
      @(negedge clk);
      apply(cap, duty, aux, od, vco, rd);
      start = 1'b1;
      if (ok) begin
         exp_q.push_back(build(cap, duty, aux, od, vco, rd));
         frames_sent++;
      end
      @(negedge clk);
      start = 1'b0;
      if (ok) begin
         chk(busy === 1'b1, {req, " R9 busy after start"}, busy, 1);
         chk(err === 1'b0, {req, " no err"}, err, 0);
         while (busy) @(negedge clk);
         repeat (3) @(negedge clk);
      end else begin
         chk(err === 1'b1, "R7 err raised", err, 1);
         chk(busy === 1'b0, "R7 busy stays low", busy, 0);
         @(negedge clk);
         chk(err === 1'b0, "R7 err one cycle", err, 0);
         chk({ser_clk, ser_data, ser_strobe, busy} === 4'b0, "R7 lines idle",
             {ser_clk, ser_data, ser_strobe, busy}, 0);
         repeat (4) @(negedge clk);
         chk({ser_clk, ser_strobe, busy} === 3'b0, "R7 still idle",
             {ser_clk, ser_strobe, busy}, 0);
      end
   endtask

   // scoreboard monitor
   logic        prev_clk = 1'b0, prev_data = 1'b0, prev_strobe = 1'b0;
   int          low_run = 0, high_run = 0, gap = 0, str_run = 0, nbits = 0;
   logic [23:0] rx = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (ser_clk && !prev_clk) begin
            chk(ser_data === prev_data && low_run >= SETUP_E, "R3 setup before rise", low_run, SETUP_E);
            chk(ser_strobe === 1'b0, "R2 strobe low at rise", ser_strobe, 0);
            rx = {rx[22:0], ser_data};
            nbits++;
            high_run = 1;
         end else if (ser_clk && prev_clk) begin
            if (ser_data !== prev_data) chk(0, "R4 data moved while high", ser_data, prev_data);
            high_run++;
         end else if (!ser_clk && prev_clk) begin
            chk(high_run >= HOLD_E, "R4 high time", high_run, HOLD_E);
            gap = 1;
         end else if (!ser_clk && !ser_strobe) begin
            gap++;
         end
         if (!ser_clk) begin
            if (!prev_clk && ser_data === prev_data) low_run++;
            else low_run = 1;
         end
         if (ser_strobe && !prev_strobe) begin
            chk(nbits == 24, "R1 bit count", nbits, 24);
            chk(gap >= WAIT_E, "R5 gap before strobe", gap, WAIT_E);
            if (exp_q.size() == 0) begin
               chk(0, "R8 unexpected frame", rx, 0);
            end else begin
               logic [23:0] e;
               e = exp_q.pop_front();
               chk(rx === e, "R1 frame contents", rx, e);
            end
            str_run = 1;
            nbits = 0;
         end else if (ser_strobe) begin
            str_run++;
            if (ser_clk) chk(0, "R2 ser_clk during strobe", ser_clk, 0);
         end else if (!ser_strobe && prev_strobe) begin
            chk(str_run == PULSE_E, "R6 strobe width", str_run, PULSE_E);
            chk(done === 1'b1, "R9 done at strobe fall", done, 1);
         end
         if (done) begin
            dones_seen++;
            if (!(prev_strobe && !ser_strobe)) chk(0, "R9 stray done", done, 0);
         end
         prev_clk = ser_clk; prev_data = ser_data; prev_strobe = ser_strobe;
      end
   end

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog R9 transfer did not finish actual=timeout expected=idle");
      summary();
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      chk({ser_clk, ser_data, ser_strobe, busy, done, err} === 6'b0, "R10 outputs in reset",
          {ser_clk, ser_data, ser_strobe, busy, done, err}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk({ser_clk, ser_data, ser_strobe, busy, done, err} === 6'b0, "R10 outputs after reset",
          {ser_clk, ser_data, ser_strobe, busy, done, err}, 0);

      // R1 reference example: expected stream 0x318A3B
      chk(build(2'b00, 1'b1, 2'b10, 3'b001, 9'd276, 7'd59) === 24'h318A3B, "R1 reference packing",
          build(2'b00, 1'b1, 2'b10, 3'b001, 9'd276, 7'd59), 24'h318A3B);
      send(2'b00, 1'b1, 2'b10, 3'b001, 9'd276, 7'd59, 1'b1, "R1");
      // R11 boundaries
      send(2'b01, 1'b0, 2'b01, 3'b110, 9'd4,   7'd1,   1'b1, "R11 low");
      send(2'b11, 1'b1, 2'b11, 3'b111, 9'd511, 7'd127, 1'b1, "R11 high");
      // R1 alternating patterns
      send(2'b10, 1'b0, 2'b10, 3'b101, 9'h155, 7'h2A, 1'b1, "R1 alt a");
      send(2'b01, 1'b1, 2'b01, 3'b010, 9'h0AA, 7'h55, 1'b1, "R1 alt b");
      // R7 illegal words
      send(2'b00, 1'b0, 2'b00, 3'b000, 9'd3,   7'd10, 1'b0, "R7");
      send(2'b11, 1'b1, 2'b11, 3'b111, 9'd300, 7'd0,  1'b0, "R7");
      send(2'b00, 1'b0, 2'b00, 3'b000, 9'd0,   7'd0,  1'b0, "R7");

      // R8 start while busy is ignored
      @(negedge clk);
      apply(2'b10, 1'b1, 2'b00, 3'b011, 9'd100, 7'd20);
      start = 1'b1;
      exp_q.push_back(build(2'b10, 1'b1, 2'b00, 3'b011, 9'd100, 7'd20));
      frames_sent++;
      @(negedge clk);
      start = 1'b0;
      repeat (7) @(negedge clk);
      apply(2'b01, 1'b0, 2'b11, 3'b100, 9'd400, 7'd90);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy === 1'b1, "R8 still busy after ignored start", busy, 1);
      while (busy) @(negedge clk);
      repeat (60) @(negedge clk);
      chk(busy === 1'b0, "R8 no second transfer", busy, 0);

      chk(exp_q.size() == 0, "R8 all frames seen", exp_q.size(), 0);
      chk(dones_seen == frames_sent, "R9 one done per frame", dones_seen, frames_sent);
      summary();
      $finish;
   end

endmodule